// File: doc/BRIEF.md
# Indexed Memory Read Window

This block gives a host access to three small internal memories through a register bus, with one fixed register address per memory and no direct addressing of the entries. A separate pointer register holds a 16-bit entry pointer and a 16-bit stride. Each host read of a memory window returns the entry the pointer selects, then moves the pointer forward by the stride. The next window read uses the new pointer.

Software sets up the pointer register before it reads a window. Writing pointer 0 and stride 1, then reading one window repeatedly, walks a whole memory in order. Other strides step through the memory with gaps, and a stride of 0 re-reads the same entry. Each memory uses the pointer modulo its depth, so a pointer larger than the memory wraps instead of faulting. A separate load port fills the memories. It stands in for their normal write path.

Top module: `ixmem_port`

## Requirements
- R1: After reset, bus_rvalid_o and bus_rdata_o are zero, and the pointer register reads back as zero.
- R2: A bus write to address 0x0 loads the pointer from write data bits 15:0 and the stride from bits 31:16. A read of address 0x0 returns the pointer in bits 15:0 and the stride in bits 31:16, with bits 63:32 zero.
- R3: For every bus read, bus_rvalid_o is high for exactly the one cycle after the read strobe, and the data is valid in that cycle. bus_rvalid_o is low in every other cycle.
- R4: A read of address 0x1, 0x2 or 0x3 returns the entry of memory 0 (32 entries), memory 1 (256 entries) or memory 2 (256 entries) that the current pointer selects. All entries are 64 bits wide.
- R5: After each window read, the pointer becomes pointer plus stride, and the next read uses the new value. A stride of 0 returns the same entry again.
- R6: With pointer 0 and stride 1, consecutive reads of one window return every entry of that memory in ascending order.
- R7: A memory is addressed with the pointer modulo its depth. For example, pointer 33 on memory 0 selects entry 1.
- R8: Reads of address 0x0 or of any unmapped address leave the pointer and the stride unchanged. An unmapped read returns zero.
- R9: The pointer addition wraps modulo 2^16. For example, pointer 0xFFFF with stride 2 becomes 0x0001.
- R10: When bus_wr_i and bus_rd_i are high in the same cycle, only the write takes effect. No data is returned and the pointer does not advance.
- R11: When mem_we_i is high, the load port writes mem_wdata_i into memory mem_sel_i (0 to 2) at mem_waddr_i modulo that memory's depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 64 | Register write data |
| bus_rdata_o | output | 64 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| mem_we_i | input | 1 | Load port write enable |
| mem_sel_i | input | 2 | Load port target memory |
| mem_waddr_i | input | 8 | Load port entry address |
| mem_wdata_i | input | 64 | Load port data |

## Verification
Read data and bus_rvalid_o come from one register stage, so they are due in the cycle right after the strobe. The pointer advance takes effect at the same edge, so the next read already sees it. The bench drives each strobe on a falling edge for one cycle and samples the outputs on the following falling edge, which falls inside that single valid cycle. It also samples one cycle later to confirm that the valid pulse has ended. Pointer effects are observed only through later reads of the pointer register or of a window, never from inside the design.

// File: rtl/ixmem_pkg.sv
package ixmem_pkg;
  localparam int unsigned IDX_W    = 16;
  localparam int unsigned NUM_MEM  = 3;
  localparam int unsigned SEL_W    = $clog2(NUM_MEM);
  localparam int unsigned PTR_ADDR = 0;
  localparam int unsigned MEM_BASE = 1;

  typedef struct packed {
    logic [IDX_W-1:0] stride;
    logic [IDX_W-1:0] ptr;
  } ptr_reg_t;
endpackage

// File: rtl/ixmem_decode.sv
module ixmem_decode
  import ixmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               ptr_hit_o,
  output logic [NUM_MEM-1:0] mem_hit_o
);
  assign ptr_hit_o = (addr_i == ADDR_W'(PTR_ADDR));

  for (genvar k = 0; k < NUM_MEM; k++) begin : g_hit
    assign mem_hit_o[k] = (addr_i == ADDR_W'(MEM_BASE + k));
  end
endmodule

// File: rtl/ixmem_index.sv
module ixmem_index
  import ixmem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  ptr_reg_t         load_val_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic [IDX_W-1:0] stride_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o    <= '0;
      stride_o <= '0;
    end else if (load_i) begin
      ptr_o    <= load_val_i.ptr;
      stride_o <= load_val_i.stride;
    end else if (adv_i) begin
      ptr_o <= ptr_o + stride_o; // wraps mod 2^IDX_W
    end
  end
endmodule

// File: rtl/ixmem_bank.sv
module ixmem_bank
  import ixmem_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned LOAD_AW = 8
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [LOAD_AW-1:0] waddr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [IDX_W-1:0]   raddr_i,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              unused_bits;

  // Depth is a power of two: modulo is the low address bits.
  assign unused_bits = ^{waddr_i, raddr_i};

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i[AW-1:0]] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i[AW-1:0]];
endmodule

// File: rtl/ixmem_port.sv
module ixmem_port
  import ixmem_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned LOAD_AW = 8,
  parameter int unsigned DEPTH0  = 32,
  parameter int unsigned DEPTH1  = 256,
  parameter int unsigned DEPTH2  = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               bus_rvalid_o,
  input  logic               mem_we_i,
  input  logic [SEL_W-1:0]   mem_sel_i,
  input  logic [LOAD_AW-1:0] mem_waddr_i,
  input  logic [DATA_W-1:0]  mem_wdata_i
);
  localparam int unsigned PAD_W = DATA_W - 2 * IDX_W;

  logic               ptr_hit;
  logic [NUM_MEM-1:0] mem_hit;
  logic               rd_go;
  logic               ptr_load;
  logic               ptr_adv;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   inc_q;
  ptr_reg_t           load_val;
  logic [DATA_W-1:0]  bank_q [NUM_MEM];
  logic [DATA_W-1:0]  rdata_d;
  logic               unused_wdata;

  ixmem_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (bus_addr_i),
    .ptr_hit_o (ptr_hit),
    .mem_hit_o (mem_hit)
  );

  // Write has priority over a read in the same cycle.
  assign rd_go    = bus_rd_i & ~bus_wr_i;
  assign ptr_load = bus_wr_i & ptr_hit;
  assign ptr_adv  = rd_go & (|mem_hit);
  assign load_val = ptr_reg_t'(bus_wdata_i[2*IDX_W-1:0]);
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:2*IDX_W];

  ixmem_index u_idx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (load_val),
    .adv_i      (ptr_adv),
    .ptr_o      (idx_q),
    .stride_o   (inc_q)
  );

  for (genvar g = 0; g < NUM_MEM; g++) begin : g_bank
    localparam int unsigned D = (g == 0) ? DEPTH0 : ((g == 1) ? DEPTH1 : DEPTH2);
    ixmem_bank #(
      .DATA_W  (DATA_W),
      .DEPTH   (D),
      .LOAD_AW (LOAD_AW)
    ) u_bank (
      .clk_i   (clk_i),
      .we_i    (mem_we_i && (mem_sel_i == SEL_W'(g))),
      .waddr_i (mem_waddr_i),
      .wdata_i (mem_wdata_i),
      .raddr_i (idx_q),
      .rdata_o (bank_q[g])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (ptr_hit) rdata_d = {{PAD_W{1'b0}}, inc_q, idx_q};
    for (int k = 0; k < NUM_MEM; k++) begin
      if (mem_hit[k]) rdata_d = bank_q[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
    end else begin
      bus_rvalid_o <= rd_go;
      if (rd_go) bus_rdata_o <= rdata_d;
    end
  end
endmodule

// File: rtl/ixmem_chk.sv
module ixmem_chk
  import ixmem_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              bus_rvalid_o,
  input logic [IDX_W-1:0]  idx_q,
  input logic [IDX_W-1:0]  inc_q
);
  logic rd_only;
  logic in_win;
  logic at_ptr;

  assign rd_only = bus_rd_i && !bus_wr_i;
  assign in_win  = (32'(bus_addr_i) >= MEM_BASE) && (32'(bus_addr_i) < MEM_BASE + NUM_MEM);
  assign at_ptr  = (32'(bus_addr_i) == PTR_ADDR);

  AST_RVALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_only |=> bus_rvalid_o); // R3
  AST_RVALID_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_only |=> !bus_rvalid_o); // R3
  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_only && in_win) |=> (idx_q == IDX_W'($past(idx_q) + $past(inc_q)))); // R5
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_only && !in_win) |=> ($stable(idx_q) && $stable(inc_q))); // R8
  AST_PTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && at_ptr) |=> (idx_q == $past(bus_wdata_i[IDX_W-1:0]))); // R2
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_only && at_ptr) |=> (bus_rdata_o[DATA_W-1:2*IDX_W] == '0)); // R2
  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_wr_i) |=> !bus_rvalid_o); // R10
endmodule

bind ixmem_port ixmem_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_wr_i     (bus_wr_i),
  .bus_rd_i     (bus_rd_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .bus_rvalid_o (bus_rvalid_o),
  .idx_q        (idx_q),
  .inc_q        (inc_q)
);

// File: tb/tb_ixmem_port.sv
module tb_ixmem_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_rvalid;
  logic        mem_we = 1'b0;
  logic [1:0]  mem_sel = '0;
  logic [7:0]  mem_waddr = '0;
  logic [63:0] mem_wdata = '0;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_mem [3][256];
  int depth [3] = '{32, 256, 256};

  always #4 clk = ~clk;

  ixmem_port dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
    .mem_we_i(mem_we), .mem_sel_i(mem_sel), .mem_waddr_i(mem_waddr), .mem_wdata_i(mem_wdata)
  );

  function automatic logic [63:0] pat(int k, int i);
    return {8'hA0 + 8'(k), 8'(i), 48'(i * 48'h10001 + k * 7 + 48'h3C00)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [63:0] d, output logic v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic load(int k, int a, logic [63:0] d);
    @(negedge clk);
    mem_we = 1'b1; mem_sel = 2'(k); mem_waddr = 8'(a); mem_wdata = d;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic set_ptr(int p, int s);
    bus_write(4'h0, {32'h0, 16'(s), 16'(p)});
  endtask

  task automatic t_reset();
    logic [63:0] d; logic v;
    chk("R1 rvalid at reset", 64'(bus_rvalid), 64'd0);
    chk("R1 rdata at reset", bus_rdata, 64'd0);
    bus_read(4'h0, d, v);
    chk("R1 pointer after reset", d, 64'd0);
  endtask

  task automatic t_fill();
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < depth[k]; i++) begin
        exp_mem[k][i] = pat(k, i);
        load(k, i, exp_mem[k][i]);
      end
  endtask

  task automatic t_ptr_rw();
    logic [63:0] d; logic v;
    bus_write(4'h0, 64'hDEAD_BEEF_0005_1234);
    bus_read(4'h0, d, v);
    chk("R2 pointer readback", d, 64'h0000_0000_0005_1234);
    chk("R3 rvalid on pointer read", 64'(v), 64'd1);
  endtask

  task automatic t_latency();
    logic [63:0] d; logic v;
    set_ptr(4, 1);
    bus_read(4'h1, d, v);
    chk("R3 rvalid one cycle after strobe", 64'(v), 64'd1);
    chk("R4 mem0 entry 4", d, exp_mem[0][4]);
    @(negedge clk);
    chk("R3 rvalid drops after one cycle", 64'(bus_rvalid), 64'd0);
  endtask

  task automatic t_sweep();
    logic [63:0] d; logic v;
    for (int k = 0; k < 3; k++) begin
      set_ptr(0, 1);
      for (int i = 0; i < depth[k]; i++) begin
        bus_read(4'(k + 1), d, v);
        chk($sformatf("R6 R11 sweep mem%0d entry %0d", k, i), d, exp_mem[k][i]);
      end
    end
  endtask

  task automatic t_stride();
    logic [63:0] d; logic v;
    set_ptr(3, 7);
    for (int n = 0; n < 5; n++) begin
      bus_read(4'h3, d, v);
      chk("R5 stride 7 on mem2", d, exp_mem[2][3 + 7 * n]);
    end
    bus_read(4'h0, d, v);
    chk("R5 pointer after five reads", d, {32'h0, 16'd7, 16'd38});
    set_ptr(9, 0);
    for (int n = 0; n < 3; n++) begin
      bus_read(4'h2, d, v);
      chk("R5 stride 0 repeats entry", d, exp_mem[1][9]);
    end
  endtask

  task automatic t_depth_wrap();
    logic [63:0] d; logic v;
    set_ptr(33, 67);
    bus_read(4'h1, d, v);
    chk("R7 mem0 pointer 33", d, exp_mem[0][1]);
    bus_read(4'h1, d, v);
    chk("R7 mem0 pointer 100", d, exp_mem[0][4]);
    set_ptr(16'h0305, 0);
    bus_read(4'h3, d, v);
    chk("R7 mem2 pointer 0x305", d, exp_mem[2][5]);
  endtask

  task automatic t_wrap16();
    logic [63:0] d; logic v;
    set_ptr(16'hFFFF, 2);
    bus_read(4'h2, d, v);
    chk("R9 mem1 pointer 0xFFFF", d, exp_mem[1][255]);
    bus_read(4'h0, d, v);
    chk("R9 pointer wraps to 1", d, {32'h0, 16'd2, 16'd1});
    bus_read(4'h2, d, v);
    chk("R9 read after wrap", d, exp_mem[1][1]);
  endtask

  task automatic t_no_adv();
    logic [63:0] d; logic v;
    set_ptr(5, 3);
    bus_read(4'h0, d, v);
    bus_read(4'h9, d, v);
    chk("R8 unmapped read data", d, 64'd0);
    chk("R8 unmapped read valid", 64'(v), 64'd1);
    bus_read(4'h0, d, v);
    chk("R8 pointer unchanged", d, {32'h0, 16'd3, 16'd5});
    bus_read(4'h1, d, v);
    chk("R8 next window read uses held pointer", d, exp_mem[0][5]);
  endtask

  task automatic t_wr_wins();
    logic [63:0] d; logic v;
    set_ptr(2, 1);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 4'h0; bus_wdata = {32'h0, 16'd1, 16'd9};
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R10 no rvalid on collision", 64'(bus_rvalid), 64'd0);
    bus_read(4'h0, d, v);
    chk("R10 write applied, no advance", d, {32'h0, 16'd1, 16'd9});
  endtask

  task automatic t_load_wrap();
    logic [63:0] d; logic v;
    load(0, 37, 64'h1122_3344_5566_7788);
    exp_mem[0][5] = 64'h1122_3344_5566_7788;
    set_ptr(5, 0);
    bus_read(4'h1, d, v);
    chk("R11 load address modulo depth", d, exp_mem[0][5]);
    load(3, 6, 64'hFFFF_0000_FFFF_0000);
    set_ptr(6, 0);
    for (int k = 0; k < 3; k++) begin
      bus_read(4'(k + 1), d, v);
      chk("R11 select 3 writes nothing", d, exp_mem[k][6]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_ptr_rw();
    t_latency();
    t_sweep();
    t_stride();
    t_depth_wrap();
    t_wrap16();
    t_no_adv();
    t_wr_wins();
    t_load_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule